// File: doc/BRIEF.md
# Masked Interrupt Collector

This block gathers twelve interrupt causes onto one shared, active-low request line. Eight causes come from timers: each one arrives as a level that is high while that timer's count is zero. The other four are alarm levels: far-end signal too high, far-end signal too low, signal-to-noise alarm and scrambler lock detect. Each cause has its own pending bit and its own enable bit. The request line is pulled low whenever any pending bit that is enabled is set.

Timer causes are edge events. A pending bit is set when the count-is-zero level rises, and a level that stays high does not set it again. Alarm causes are sticky. Their pending bit stays set for as long as the alarm level is present, and a clear only takes effect after the alarm has gone away. Software reads and clears pending bits through a small byte-wide register port. A pending bit is cleared by writing 1 to it.

The line is open-drain. The block never drives it high. Its output is an enable that, while high, pulls the shared line low. This lets several devices share one pulled-up wire.

Top module: `irq_collector`

## Requirements
- R1: After reset, both enable registers and both pending registers read 0 and `irqPullLow` is 0.
- R2: Address 0x02 holds the timer enables: bit i set enables timer i. Address 0x03 holds the alarm enables in bits 3:0, and bits 7:4 read 0. Bit 0 is far-end high, bit 1 far-end low, bit 2 the signal-to-noise alarm and bit 3 scrambler lock. A write takes effect at the clock edge where it is sampled, and the register reads back the written value.
- R3: Address 0x04 reads the timer pending bits. Bit i becomes 1 at the clock edge where `timerZero[i]` is sampled high after having been sampled low at the previous edge.
- R4: A `timerZero[i]` level that stays high does not set bit i again after the bit is cleared. A level that is already high when reset ends produces no event.
- R5: Address 0x05 reads the alarm pending bits in the same bit order as R2. An alarm bit is 1 at every edge where its `alarmLevel` input is sampled high.
- R6: Writing to address 0x04 or 0x05 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 are left as they are.
- R7: A clear write does not clear an alarm pending bit while its alarm level is still high. The same clear takes effect once the level is low.
- R8: When a clear of a pending bit and a new event for that bit happen at the same edge, the bit stays 1.
- R9: `irqPullLow` is 1 exactly when some pending bit and its enable bit are both 1. Clearing an enable bit hides the cause from the line but keeps its pending bit.
- R10: Addresses other than 0x02 to 0x05 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address for reads and writes |
| regWrEn | input | 1 | Write strobe, sampled at the rising edge |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| timerZero | input | 8 | One count-is-zero level per timer |
| alarmLevel | input | 4 | Alarm condition levels |
| irqPullLow | output | 1 | High to pull the shared request line low |

## Verification
A pending bit held in the wrong state shows up in the same cycle: it appears in the read of 0x04 or 0x05, and on `irqPullLow` when that cause is enabled. A broken edge detector shows up as a timer bit that comes back after a clear while the timer level is held high, or as a bit that stays 0 on a real rise. Both are visible one edge after the stimulus. Alarm stickiness and the rule that a set wins over a clear at the same edge are checked by writing clears while the event is present, and reading back one edge later.

// File: rtl/irqagg_pkg.sv
`timescale 1ns/1ps
package irqagg_pkg;

  // Strobes decoded by the control module from a register write.
  typedef struct packed {
    logic wrMaskT;
    logic wrMaskA;
    logic clrT;
    logic clrA;
  } regStrobes_t;

  // Which register drives the read data.
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK_T,
    SEL_MASK_A,
    SEL_STAT_T,
    SEL_STAT_A
  } rdSel_t;

endpackage

// File: rtl/irqagg_ctrl.sv
`timescale 1ns/1ps
module irqagg_ctrl
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ADDR_MASK_T = 8'h02,
  parameter logic [ADDR_W-1:0] ADDR_MASK_A = 8'h03,
  parameter logic [ADDR_W-1:0] ADDR_STAT_T = 8'h04,
  parameter logic [ADDR_W-1:0] ADDR_STAT_A = 8'h05
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobes_t       strobes,
  output rdSel_t            rdSel
);

  always_comb begin
    rdSel = SEL_NONE;
    if (regAddr == ADDR_MASK_T) rdSel = SEL_MASK_T;
    else if (regAddr == ADDR_MASK_A) rdSel = SEL_MASK_A;
    else if (regAddr == ADDR_STAT_T) rdSel = SEL_STAT_T;
    else if (regAddr == ADDR_STAT_A) rdSel = SEL_STAT_A;
  end

  // Unmapped addresses give no strobe, so their writes are dropped (R10)
  always_comb begin
    strobes.wrMaskT = regWrEn && (rdSel == SEL_MASK_T);
    strobes.wrMaskA = regWrEn && (rdSel == SEL_MASK_A);
    strobes.clrT    = regWrEn && (rdSel == SEL_STAT_T);
    strobes.clrA    = regWrEn && (rdSel == SEL_STAT_A);
  end

endmodule

// File: rtl/irqagg_datapath.sv
`timescale 1ns/1ps
module irqagg_datapath
  import irqagg_pkg::*;
#(
  parameter int NUM_TIMERS = 8,
  parameter int NUM_ALARMS = 4,
  parameter int DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobes_t           strobes,
  input  rdSel_t                rdSel,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NUM_TIMERS-1:0] timerZero,
  input  logic [NUM_ALARMS-1:0] alarmLevel,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irqPullLow
);

  logic [NUM_TIMERS-1:0] tMask, tStat, prevZero, tRise;
  logic [NUM_ALARMS-1:0] aMask, aStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tMask <= '0;
      aMask <= '0;
    end else begin
      if (strobes.wrMaskT) tMask <= wrData[NUM_TIMERS-1:0];
      if (strobes.wrMaskA) aMask <= wrData[NUM_ALARMS-1:0];
    end
  end

  // One edge-detecting pending cell per timer
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_timer
    assign tRise[i] = timerZero[i] && !prevZero[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevZero[i] <= 1'b1;   // a level already high at reset is not an event
        tStat[i]    <= 1'b0;
      end else begin
        prevZero[i] <= timerZero[i];
        tStat[i]    <= (tStat[i] && !(strobes.clrT && wrData[i])) || tRise[i];
      end
    end

    a_r3_rise_only: assert property (@(posedge clk) disable iff (!rstN)
      $rose(tStat[i]) |-> ($past(timerZero[i]) && !$past(timerZero[i], 2)));
    a_r6_clear_by_write: assert property (@(posedge clk) disable iff (!rstN)
      $fell(tStat[i]) |-> $past(strobes.clrT && wrData[i]));
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.clrT && wrData[i] && tRise[i]) |=> tStat[i]);
  end

  // Sticky pending cell per alarm: the live level keeps it set
  for (genvar j = 0; j < NUM_ALARMS; j++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (!rstN) aStat[j] <= 1'b0;
      else aStat[j] <= (aStat[j] && !(strobes.clrA && wrData[j])) || alarmLevel[j];
    end

    a_r7_held_while_active: assert property (@(posedge clk) disable iff (!rstN)
      alarmLevel[j] |=> aStat[j]);
    a_r5_set_from_level: assert property (@(posedge clk) disable iff (!rstN)
      $rose(aStat[j]) |-> $past(alarmLevel[j]));
  end

  assign irqPullLow = |(tStat & tMask) || |(aStat & aMask);

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      SEL_MASK_T: rdData[NUM_TIMERS-1:0] = tMask;
      SEL_MASK_A: rdData[NUM_ALARMS-1:0] = aMask;
      SEL_STAT_T: rdData[NUM_TIMERS-1:0] = tStat;
      SEL_STAT_A: rdData[NUM_ALARMS-1:0] = aStat;
      default:    rdData = '0;
    endcase
  end

  a_r9_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (tMask == '0 && aMask == '0) |-> !irqPullLow);
  a_r9_mask_keeps_status: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.clrT && !strobes.clrA) |=> ((tStat & $past(tStat)) == $past(tStat)));

endmodule

// File: rtl/irq_collector.sv
`timescale 1ns/1ps
module irq_collector
  import irqagg_pkg::*;
#(
  parameter int NUM_TIMERS = 8,
  parameter int NUM_ALARMS = 4,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [NUM_TIMERS-1:0] timerZero,
  input  logic [NUM_ALARMS-1:0] alarmLevel,
  output logic                  irqPullLow
);

  regStrobes_t strobes;
  rdSel_t      rdSel;

  irqagg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  irqagg_datapath #(
    .NUM_TIMERS(NUM_TIMERS),
    .NUM_ALARMS(NUM_ALARMS),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .wrData     (regWrData),
    .timerZero  (timerZero),
    .alarmLevel (alarmLevel),
    .rdData     (regRdData),
    .irqPullLow (irqPullLow)
  );

endmodule

// File: tb/irq_collector_tb.sv
`timescale 1ns/1ps
module irq_collector_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] regAddr, regWrData, regRdData;
  logic       regWrEn, irqPullLow;
  logic [7:0] timerZero;
  logic [3:0] alarmLevel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Model state
  logic [7:0] mTm, mTs, mPrev;
  logic [3:0] mAm, mAs;

  always #10 clk = ~clk;   // 50 MHz

  irq_collector u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .timerZero(timerZero),
    .alarmLevel(alarmLevel), .irqPullLow(irqPullLow)
  );

  function automatic logic [7:0] expRead(input logic [7:0] a);
    case (a)
      8'h02: expRead = mTm;
      8'h03: expRead = {4'h0, mAm};
      8'h04: expRead = mTs;
      8'h05: expRead = {4'h0, mAs};
      default: expRead = 8'h00;
    endcase
  endfunction

  function automatic logic expIrq();
    expIrq = |(mTs & mTm) || |(mAs & mAm);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic checkReg(input string req, input logic [7:0] a);
    regAddr = a;
    #1;
    check(req, regRdData, expRead(a));
  endtask

  task automatic checkIrq(input string req);
    check(req, {7'd0, irqPullLow}, {7'd0, expIrq()});
  endtask

  // One sampled edge with the given inputs; the model follows the requirements.
  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] tz, input logic [3:0] al);
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; timerZero = tz; alarmLevel = al;
    @(posedge clk);
    if (we && a == 8'h02) mTm = d;
    if (we && a == 8'h03) mAm = d[3:0];
    mTs = (mTs & ~((we && a == 8'h04) ? d : 8'h00)) | (tz & ~mPrev);
    mAs = (mAs & ~((we && a == 8'h05) ? d[3:0] : 4'h0)) | al;
    mPrev = tz;
    #1 regWrEn = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] tz;
    logic [3:0] al;
    void'($urandom(32'h5eed1234));
    rstN = 1'b0; regWrEn = 1'b0; regAddr = 8'h00; regWrData = 8'h00;
    timerZero = 8'h01; alarmLevel = 4'h0;
    mTm = 0; mAm = 0; mTs = 0; mAs = 0; mPrev = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    mPrev = 8'h01;
    // R1 reset state; R4 level already high at reset gives no event
    checkReg("R1", 8'h02); checkReg("R1", 8'h03);
    checkReg("R4", 8'h04); checkReg("R1", 8'h05);
    checkIrq("R1");

    // R2 enable registers
    step(1, 8'h02, 8'hA5, 8'h01, 4'h0);
    checkReg("R2", 8'h02);
    step(1, 8'h03, 8'hFF, 8'h01, 4'h0);
    checkReg("R2", 8'h03);
    // R10 unmapped address
    step(1, 8'h07, 8'hFF, 8'h01, 4'h0);
    checkReg("R10", 8'h07); checkReg("R10", 8'h02); checkReg("R10", 8'h04);

    // R3 timer 3 rises; bit 3 disabled in 0xA5 so R9 line stays released
    step(0, 8'h00, 8'h00, 8'h09, 4'h0);
    checkReg("R3", 8'h04); checkIrq("R9");
    check("R9", {7'd0, irqPullLow}, 8'h00);
    step(1, 8'h02, 8'h08, 8'h09, 4'h0);
    check("R9", {7'd0, irqPullLow}, 8'h01);
    // R6 write of 0 leaves bit set
    step(1, 8'h04, 8'h00, 8'h09, 4'h0);
    check("R6", regRdData, 8'h08);
    // R4 clear while level stays high: not set again
    step(1, 8'h04, 8'h08, 8'h09, 4'h0);
    step(0, 8'h00, 8'h00, 8'h09, 4'h0);
    checkReg("R4", 8'h04); checkIrq("R4");

    // R5/R7 alarm 2 sticky
    step(0, 8'h00, 8'h00, 8'h09, 4'h4);
    checkReg("R5", 8'h05);
    step(1, 8'h05, 8'h04, 8'h09, 4'h4);
    checkReg("R7", 8'h05);
    check("R7", regRdData, 8'h04);
    step(1, 8'h05, 8'h04, 8'h09, 4'h0);
    checkReg("R7", 8'h05);
    check("R7", regRdData, 8'h00);

    // R8 clear and rise of timer 1 at same edge
    step(0, 8'h00, 8'h00, 8'h00, 4'h0);
    step(1, 8'h04, 8'h02, 8'h02, 4'h0);
    checkReg("R8", 8'h04);
    check("R8", regRdData, 8'h02);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      case ($urandom % 6)
        0: a = 8'h02; 1: a = 8'h03; 2, 3: a = 8'h04;
        4: a = 8'h05; default: a = 8'($urandom);
      endcase
      tz = ($urandom % 3 == 0) ? 8'($urandom) : timerZero;
      al = ($urandom % 4 == 0) ? 4'($urandom) : alarmLevel;
      step(1'($urandom), a, 8'($urandom), tz, al);
      checkIrq("R9");
      checkReg("R6", 8'h04);
      checkReg("R7", 8'h05);
      checkReg("R2", 8'($urandom % 8));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule